// File: doc/BRIEF.md
# Serial Flash Read Target with Execute-in-Place

This block is the read side of a serial flash target, as seen from the flash pins. It decodes two read commands. The first is a single-wire fast read. The second is a read that takes its address on one wire and then returns data four bits per serial clock. Data is fetched a byte at a time from a byte array outside the block, through an address/data lookup port. Each fetched byte is shifted out through a fixed four-stage output delay.

A mode byte is received after the address of a quad read, and its bit 7 decides what happens when chip select is released. If bit 7 is zero, the target stays in a continuous execute-in-place state. The next transaction then carries no opcode and starts directly with a four-bit-wide address. If bit 7 is one, the target drops back to single-wire command decoding. Program and erase logic live elsewhere; this block only watches a busy flag, and data fetched while that flag is high is replaced by zero.

Each rising edge of `clk` with `cs_n` low is one serial clock. Serial clocks are numbered from 1 after `cs_n` falls. `cs_n` high resets the bit counter and the shift registers.

Top module: `qrt_top`

## Requirements
- R1: Fast read uses opcode 0x0B, sent MSB first on `din[0]`, followed by a 24-bit address (MSB first) and 8 dummy clocks. Data bytes then stream MSB first from the address, and the address increments after each byte. Each bit appears on `dout[1]`, and `dout[3]`, `dout[2]` and `dout[0]` stay 0.
- R2: Output passes through a 4-clock delay. In a fast read, stream bit j is on `dout` after serial clock 44+j, and `dout` is all zero before clock 44.
- R3: Quad read uses opcode 0x6B. It takes a 24-bit single-wire address and then an 8-clock single-wire mode byte. From then on it returns 4 bits per clock on `dout[3:0]`, high nibble first. Stream nibble j is on `dout` after serial clock 44+j.
- R4: If bit 7 of the mode byte is 0 (the other bits do not matter), releasing `cs_n` enters execute-in-place. The next transaction then carries no opcode. Its 24-bit address arrives as 6 nibbles on `din[3:0]`, high nibble first. Next come a mode byte in 2 nibbles and 6 more clocks, and stream nibble j is on `dout` after serial clock 18+j.
- R5: If bit 7 of the mode byte is 1, releasing `cs_n` after a quad read returns the target to single-wire opcode decoding.
- R6: A mode byte received inside an execute-in-place transaction decides in the same way whether the following transaction stays in execute-in-place (bit 7 = 0) or leaves it (bit 7 = 1).
- R7: A byte fetched while `busy` is high is output as 0x00, and the address does not advance for that byte.
- R8: Any opcode other than 0x0B and 0x6B, including the slow read 0x03, is rejected. `dout` stays 0 for the rest of that transaction, and the next transaction decodes a fresh opcode.
- R9: The read address wraps modulo 2^AW (AW = 8 by default).
- R10: Synchronous active-low reset clears `dout`, leaves execute-in-place and returns the target to single-wire opcode decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge with cs_n low is one serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| din | input | 4 | Serial input; bit 0 in single-wire phases, all four in quad phases |
| busy | input | 1 | Write-in-progress flag from the program/erase logic |
| mem_addr | output | AW | Byte-array lookup address |
| mem_data | input | 8 | Byte-array data for mem_addr, same cycle |
| dout | output | 4 | Serial output after the 4-stage delay |

## Verification
The read function is driven with single-wire fast reads, with quad reads whose mode bit 7 is one, zero, or zero with the other bits set, and with chained execute-in-place transactions that either keep or leave that state. Together these runs separate the three address formats and the two output widths. A fast read that directly follows each exit proves that opcode decoding came back. Start addresses next to the top of the array expose a missing wrap, and busy held over the first fetched bytes shows both zeroing and a stalled address. A rejected 0x03 opcode, and a reset taken while in execute-in-place, are each followed by a normal fast read to show recovery.

// File: rtl/qrt_pkg.sv
// Package: shared constants and state encoding for the serial flash read target.
// Assumes one serial clock per system clock edge while chip select is low.
package qrt_pkg;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int SREG_W  = 32;   // input shift register width
    localparam int CNT_W   = 7;    // bit counter width
    localparam int ADR_BITS = 24;  // address bits on the wire

    localparam logic [7:0] OP_FAST = 8'h0B;
    localparam logic [7:0] OP_QUAD = 8'h6B;

    // Bit-count milestones
    localparam logic [CNT_W-1:0] C_OPC    = 7'd8;
    localparam logic [CNT_W-1:0] C_ADDR   = 7'd32;
    localparam logic [CNT_W-1:0] C_DATA   = 7'd40;
    localparam logic [CNT_W-1:0] C_XADDR  = 7'd24;
    localparam logic [CNT_W-1:0] C_XDATA  = 7'd56;
    localparam logic [CNT_W-1:0] C_WRAP   = 7'd96;  // fold point keeping mod-8 phase
    localparam logic [CNT_W-1:0] C_FOLD   = 7'd32;

    typedef enum logic [2:0] {
        ST_CMD,    // waiting for single-wire opcode
        ST_FAST,   // single-wire fast read
        ST_QCMD,   // quad read entered by opcode
        ST_QXIP,   // execute-in-place, waiting for quad address
        ST_QDATA,  // quad read entered without opcode
        ST_BAD     // rejected command, ignore until release
    } qrt_state_e;
endpackage

// File: rtl/qrt_ctrl.sv
// Module: command/address sequencer. Counts serial bits, decodes the opcode,
// captures address and mode byte, decides fetch points and the bus width.
// Assumes mem_data is valid combinationally for the current address.
module qrt_ctrl
    import qrt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [LANES-1:0]  din,
    input  logic              busy,
    input  logic [BYTE_W-1:0] mem_data,
    output logic [AW-1:0]     addr,
    output logic              quad,
    output logic              ld,
    output logic [BYTE_W-1:0] ld_val
);
    qrt_state_e        st_q, st_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx, cnt_sum;
    logic [SREG_W-1:0] ireg_q, ireg_nx;
    logic              quad_q, quad_nx, mode_q, mode_nx;
    logic [AW-1:0]     addr_q, addr_nx;
    logic              byte_edge;

    // Next-state logic: bit counting, decode, capture and fetch strobes.
    always_comb begin
        cnt_sum   = cnt_q + (quad_q ? CNT_W'(4) : CNT_W'(1));
        cnt_nx    = (cnt_sum >= C_WRAP) ? cnt_sum - C_FOLD : cnt_sum;
        ireg_nx   = quad_q ? {ireg_q[SREG_W-5:0], din} : {ireg_q[SREG_W-2:0], din[0]};
        byte_edge = (cnt_nx[2:0] == 3'd0);
        st_nx     = st_q;
        quad_nx   = quad_q;
        mode_nx   = mode_q;
        addr_nx   = addr_q;
        ld        = 1'b0;
        if (cs_n) begin
            if ((st_q == ST_QCMD || st_q == ST_QDATA) && !mode_q) begin
                st_nx = ST_QXIP;
            end else if (st_q != ST_QXIP) begin
                st_nx   = ST_CMD;
                quad_nx = 1'b0;
            end
        end else begin
            unique case (st_q)
                ST_CMD: if (cnt_nx == C_OPC) begin
                    if (ireg_nx[7:0] == OP_FAST) st_nx = ST_FAST;
                    else if (ireg_nx[7:0] == OP_QUAD) begin
                        st_nx   = ST_QCMD;
                        mode_nx = 1'b1;
                    end else st_nx = ST_BAD;
                end
                ST_FAST: begin
                    if (cnt_nx == C_ADDR) addr_nx = ireg_nx[AW-1:0];
                    else if (cnt_nx >= C_DATA && byte_edge) ld = 1'b1;
                end
                ST_QCMD: begin
                    if (cnt_nx == C_ADDR) addr_nx = ireg_nx[AW-1:0];
                    else if (cnt_nx == C_DATA) begin
                        ld      = 1'b1;
                        quad_nx = 1'b1;
                        mode_nx = ireg_nx[7];
                    end else if (cnt_nx > C_DATA && byte_edge) ld = 1'b1;
                end
                ST_QXIP: if (cnt_nx == C_XADDR) begin
                    addr_nx = ireg_nx[AW-1:0];
                    mode_nx = 1'b1;
                    st_nx   = ST_QDATA;
                end
                ST_QDATA: if (cnt_nx >= C_XDATA && byte_edge) begin
                    ld = 1'b1;
                    if (cnt_nx == C_XDATA) mode_nx = ireg_nx[SREG_W-1];
                end
                default: ;
            endcase
            if (ld && !busy) addr_nx = addr_q + AW'(1);
        end
        ld_val = busy ? '0 : mem_data;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_CMD;
            cnt_q  <= '0;
            ireg_q <= '0;
            quad_q <= 1'b0;
            mode_q <= 1'b1;
            addr_q <= '0;
        end else begin
            st_q   <= st_nx;
            cnt_q  <= cs_n ? '0 : cnt_nx;
            ireg_q <= cs_n ? '0 : ireg_nx;
            quad_q <= quad_nx;
            mode_q <= mode_nx;
            addr_q <= addr_nx;
        end
    end

    assign addr = addr_q;
    assign quad = quad_q;

    // Quad output only starts at the end of the mode byte of an opcode read (R3).
    assert_quad_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quad_q) |-> (st_q == ST_QCMD && cnt_q == C_DATA));
    // Execute-in-place always keeps the four-lane width (R4).
    assert_xip_quad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_QXIP) |-> quad_q);
    // Six quad clocks complete the opcode-less address (R4).
    assert_xip_addr_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_QXIP && !cs_n && cnt_q == 7'd20) |=> (st_q == ST_QDATA));
    // A rejected command never fetches (R8).
    assert_bad_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BAD) |-> !ld);
endmodule

// File: rtl/qrt_oshift.sv
// Module: output shift register. Loads a fetched byte, shifts one or four bits
// per serial clock, and presents single-wire data on lane 1 or a full nibble.
// Assumes load has priority over shift and chip select high clears it.
module qrt_oshift
    import qrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              quad,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_val,
    output logic [LANES-1:0]  nxt
);
    logic [BYTE_W-1:0] oreg_q;

    // Shift/load register for outgoing data.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) oreg_q <= '0;
        else if (ld)        oreg_q <= ld_val;
        else if (quad)      oreg_q <= {oreg_q[BYTE_W-5:0], 4'b0000};
        else                oreg_q <= {oreg_q[BYTE_W-2:0], 1'b0};
    end

    // Lane mapping for the current width.
    always_comb begin
        if (quad) nxt = oreg_q[BYTE_W-1:BYTE_W-4];
        else      nxt = {2'b00, oreg_q[BYTE_W-1], 1'b0};
    end
endmodule

// File: rtl/qrt_delay.sv
// Module: fixed-latency output delay line, DEPTH register stages of width W.
// Assumes it runs every clock regardless of chip select.
module qrt_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // One delay stage.
        always_ff @(posedge clk) begin
            if (!rst_n)      stg[g] <= '0;
            else if (g == 0) stg[g] <= d;
            else             stg[g] <= stg[(g == 0) ? 0 : g-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/qrt_top.sv
// Module: serial flash read target with fast read, quad read and
// execute-in-place. Wraps the sequencer, output shifter and delay line.
// Assumes an external byte array answering mem_addr in the same cycle.
module qrt_top
    import qrt_pkg::*;
#(
    parameter int AW      = 8,
    parameter int OUT_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [LANES-1:0]  din,
    input  logic              busy,
    output logic [AW-1:0]     mem_addr,
    input  logic [BYTE_W-1:0] mem_data,
    output logic [LANES-1:0]  dout
);
    logic              quad, ld;
    logic [BYTE_W-1:0] ld_val;
    logic [LANES-1:0]  nxt;

    qrt_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .busy(busy),
        .mem_data(mem_data), .addr(mem_addr), .quad(quad), .ld(ld), .ld_val(ld_val)
    );

    qrt_oshift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .quad(quad),
        .ld(ld), .ld_val(ld_val), .nxt(nxt)
    );

    qrt_delay #(.DEPTH(OUT_LAT), .W(LANES)) u_dly (
        .clk(clk), .rst_n(rst_n), .d(nxt), .q(dout)
    );

    // A fetch made while busy presents nothing but zeros (R7).
    assert_busy_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && busy && !cs_n) |=> (nxt == '0));
endmodule

// File: tb/tb_qrt_top.sv
// Bench: table-driven read transactions, then directed reset checks.
module tb_qrt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] din = '0;
    logic       busy = 1'b0;
    logic [7:0] mem_addr;
    logic [7:0] mem_data;
    logic [3:0] dout;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign mem_data = mem_addr ^ 8'hC3;  // byte array model

    qrt_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .busy(busy),
        .mem_addr(mem_addr), .mem_data(mem_data), .dout(dout)
    );

    // kind: 0 fast 0x0B, 1 quad 0x6B, 2 execute-in-place, 3 opcode 0x03
    // fields: kind[49:48] addr[47:24] mode[23:16] nbytes[15:8] busy_bytes[7:0]
    localparam int NV = 11;
    localparam logic [49:0] VEC [NV] = '{
        {2'd0, 24'h000010, 8'h00, 8'd3, 8'd0},
        {2'd0, 24'h0003FE, 8'h00, 8'd4, 8'd0},
        {2'd3, 24'h000010, 8'h00, 8'd3, 8'd0},
        {2'd0, 24'h000040, 8'h00, 8'd2, 8'd0},
        {2'd1, 24'h000020, 8'h80, 8'd3, 8'd0},
        {2'd0, 24'h000005, 8'h00, 8'd3, 8'd2},
        {2'd1, 24'h000033, 8'h00, 8'd2, 8'd0},
        {2'd2, 24'h000050, 8'h00, 8'd3, 8'd0},
        {2'd2, 24'h0000FF, 8'h80, 8'd2, 8'd0},
        {2'd1, 24'h0000A0, 8'h7F, 8'd2, 8'd0},
        {2'd2, 24'h000012, 8'h00, 8'd2, 8'd1}
    };

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1 R2 fast read";
            1: return "R9 fast read wrap";
            2: return "R8 opcode 0x03 rejected";
            3: return "R8 recovery fast read";
            4: return "R3 quad read, mode bit7=1";
            5: return "R5 R7 fast read after quad exit, busy";
            6: return "R3 R4 quad read entering XIP";
            7: return "R4 R6 XIP read, stays";
            8: return "R6 R9 XIP read, exits, wraps";
            9: return "R5 R4 fast-after-exit not needed; quad mode 0x7F";
            default: return "R4 R7 XIP read busy";
        endcase
    endfunction

    function automatic logic [3:0] din_val(input int kind, input logic [23:0] a,
                                           input logic [7:0] md, input int k);
        logic [7:0] op;
        op = (kind == 1) ? 8'h6B : (kind == 3) ? 8'h03 : 8'h0B;
        if (kind == 2) begin
            if (k <= 6) return a[4*(6-k) +: 4];
            if (k == 7) return md[7:4];
            if (k == 8) return md[3:0];
            return 4'h0;
        end
        if (k <= 8)  return {3'b000, op[8-k]};
        if (k <= 32) return {3'b000, a[32-k]};
        if (k <= 40 && kind == 1) return {3'b000, md[40-k]};
        return 4'h0;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] a, input int idx, input int bn);
        logic [7:0] ad;
        if (idx < bn) return 8'h00;
        ad = a[7:0] + 8'(idx - bn);
        return ad ^ 8'hC3;
    endfunction

    function automatic logic [3:0] exp_dout(input int kind, input logic [23:0] a,
                                            input int bn, input int k);
        int start, j;
        logic [7:0] b;
        if (kind == 3) return 4'h0;
        start = (kind == 2) ? 18 : 44;
        if (k < start) return 4'h0;
        j = k - start;
        if (kind == 0) begin
            b = exp_byte(a, j / 8, bn);
            return {2'b00, b[7 - (j % 8)], 1'b0};
        end
        b = exp_byte(a, j / 2, bn);
        return (j % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    task automatic run_txn(input int kind, input logic [23:0] a, input logic [7:0] md,
                           input int nb, input int bn, input string tag);
        int t, first, step, bad;
        logic [3:0] e;
        bad = 0;
        first = (kind == 2) ? 14 : 40;
        step  = (kind == 0 || kind == 3) ? 8 : 2;
        t = (kind == 2) ? 17 + 2*nb : (kind == 1) ? 43 + 2*nb : 43 + 8*nb;
        @(negedge clk);
        cs_n = 1'b0;
        din  = din_val(kind, a, md, 1);
        busy = (1 < first + bn*step);
        for (int k = 1; k <= t; k++) begin
            @(posedge clk);
            @(negedge clk);
            e = exp_dout(kind, a, bn, k);
            if (dout !== e && bad == 0) begin
                $display("FAIL %s: clock %0d dout=%h expected %h", tag, k, dout, e);
                bad = 1;
            end
            if (k < t) begin
                din  = din_val(kind, a, md, k + 1);
                busy = (k + 1 < first + bn*step);
            end else begin
                cs_n = 1'b1;
                din  = '0;
                busy = 1'b0;
            end
        end
        checks++;
        if (bad != 0) errors++;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if (dout !== 4'h0) begin
            errors++;
            $display("FAIL %s: dout=%h expected 0", tag, dout);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R10 dout during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R10 dout after reset");
        for (int i = 0; i < NV; i++)
            run_txn(int'(VEC[i][49:48]), VEC[i][47:24], VEC[i][23:16],
                    int'(VEC[i][15:8]), int'(VEC[i][7:0]), tag_of(i));
        // Directed: reset while in execute-in-place, then single-wire opcode
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_zero("R10 dout in reset from XIP");
        rst_n = 1'b1;
        run_txn(0, 24'h000030, 8'h00, 2, 0, "R10 fast read after reset in XIP");
        // Directed: quad read exit then fast read decodes opcode again
        run_txn(1, 24'h000060, 8'hFF, 1, 0, "R3 quad read mode 0xFF");
        run_txn(0, 24'h000061, 8'h00, 1, 0, "R5 fast read after exit");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule